// File: doc/BRIEF.md
# Static Memory Write-Cycle Sequencer with External Wait

This block produces a single write cycle toward an asynchronous static memory device, timed entirely on the system clock. A start strobe, given while the block is idle, loads a write wait-state count and drives an active-low chip select and an active-low write enable. The two strobes go low together because the write-enable delay is fixed at zero. A countdown then runs through the programmed number of clock cycles, and when it ends a one-cycle done pulse is raised.

A slow device can lengthen the cycle through an active-low wait input. The wait input crosses a two-stage synchronizer, and only samples that land near the end of the countdown are honoured. Any honoured low sample makes the sequencer stop at the second-to-last count and hold there for as long as the synchronized wait stays low. When a high sample arrives, the transaction is committed and closes on a fixed schedule. Write enable releases first and chip select releases one cycle later. A stretch that lasts too long is cut off by a hold limit and then closes as if the wait had gone high.

Top module: `wseq_top`

## Requirements
- R1: After reset, and whenever `busy` is low, `cs_n` and `we_n` are high and `done` is low.
- R2: A `start` sampled high while idle drives `cs_n` and `we_n` low together at the next clock edge, and `busy` goes high at that same edge.
- R3: With no honoured wait, `cs_n` and `we_n` stay low for exactly N cycles, where N is the effective wait-state count. Both then rise together, and `done` is high for that one cycle only.
- R4: A `wst` value below 3 is treated as 3, so a cycle never lasts fewer than three strobe cycles.
- R5: `wait_n` is seen through two flops. The sample used in a cycle is the `wait_n` level two edges earlier. The active cycles are numbered with a countdown value from N-1 down to 0. A low sample seen while that value is above 3 is ignored and does not change the cycle length.
- R6: A low sample seen while the countdown value is 3, 2 or 1 causes the sequencer to stop at value 1 and enter a stretch. This holds even if the sample has returned high by then. The stretch continues for every cycle in which the sample is low.
- R7: In the stretch cycle where the sample is first high, the transaction commits. `we_n` rises 5 cycles later. `cs_n` rises 6 cycles later, with `done` high in that cycle. Later wait samples have no effect.
- R8: A stretch lasts at most HOLD_MAX cycles. If the sample is still low in the last of them, the sequencer commits as in R7. The default HOLD_MAX of 16365 sets the width of the hold counter.
- R9: `start` has no effect while `busy` is high. `busy` stays high from the edge that accepts `start` through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one write cycle (used only when idle) |
| wst | input | WST_W | Write wait-state count, clamped up to 3 |
| wait_n | input | 1 | Active-low stretch request from the device, asynchronous |
| cs_n | output | 1 | Active-low chip select |
| we_n | output | 1 | Active-low write enable |
| done | output | 1 | One-cycle pulse at the end of the cycle |
| busy | output | 1 | High while a cycle is in progress, through `done` |

## Verification
The bench builds the block with WST_W of 6 and HOLD_MAX of 12. The short hold limit puts the forced commit of R8 within a run of a few dozen cycles instead of sixteen thousand. The 6-bit count still allows cycles long enough that early wait pulses fall entirely outside the window, as R5 requires. The synchronizer depth stays at its default of two, so the bench can place each wait pulse at an exact countdown value.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COUNT,
      ST_HOLD,
      ST_TAIL,
      ST_DONE
   } wseq_state_e;

   // smallest legal write wait-state count
   localparam int WSEQ_MIN_WST  = 3;
   // countdown value at and below which wait samples are honoured
   localparam int WSEQ_WIN_OPEN = 3;

endpackage

// File: rtl/wseq_sync.sv
module wseq_sync #(
   parameter int  STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] stage_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= RST_VAL;
               else        stage_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[gi] <= RST_VAL;
               else        stage_q[gi] <= stage_q[gi-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/wseq_countdown.sv
module wseq_countdown
   import wseq_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         is_one,
   output logic         is_zero,
   output logic         in_win
);

   localparam logic [W-1:0] ONE_V = W'(1);
   localparam logic [W-1:0] WIN_V = W'(WSEQ_WIN_OPEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (dec)  cnt <= cnt - ONE_V;
   end

   assign is_one  = (cnt == ONE_V);
   assign is_zero = (cnt == '0);
   assign in_win  = (cnt <= WIN_V);

endmodule

// File: rtl/wseq_window.sv
module wseq_window (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic active,
   input  logic in_win,
   input  logic low,
   output logic hit
);

   logic armed_q;
   logic take;

   assign take = active & in_win & low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    armed_q <= 1'b0;
      else if (clr)  armed_q <= 1'b0;
      else if (take) armed_q <= 1'b1;
   end

   assign hit = armed_q | take;

endmodule

// File: rtl/wseq_holdctr.sv
module wseq_holdctr #(
   parameter int HOLD_MAX = 16365
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);

   localparam int HW = (HOLD_MAX > 1) ? $clog2(HOLD_MAX) : 1;

   generate
      if (HOLD_MAX == 1) begin : g_single
         // every stretch cycle is the last one
         assign last = 1'b1;
      end else begin : g_count
         localparam logic [HW-1:0] LAST_V = HW'(HOLD_MAX - 1);
         localparam logic [HW-1:0] STEP_V = HW'(1);
         logic [HW-1:0] hcnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    hcnt <= '0;
            else if (clr)                  hcnt <= '0;
            else if (inc && hcnt != LAST_V) hcnt <= hcnt + STEP_V;
         end

         assign last = (hcnt == LAST_V);
      end
   endgenerate

endmodule

// File: rtl/wseq_top.sv
module wseq_top
   import wseq_pkg::*;
#(
   parameter int WST_W       = 8,
   parameter int HOLD_MAX    = 16365,
   parameter int SYNC_STAGES = 2,
   parameter int WE_RELEASE  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WST_W-1:0] wst,
   input  logic             wait_n,
   output logic             cs_n,
   output logic             we_n,
   output logic             done,
   output logic             busy
);

   localparam int TW = $clog2(WE_RELEASE);
   localparam logic [WST_W-1:0] MIN_V   = WST_W'(WSEQ_MIN_WST);
   localparam logic [WST_W-1:0] ONE_V   = WST_W'(1);
   localparam logic [TW-1:0]    TLAST_V = TW'(WE_RELEASE - 1);
   localparam logic [TW-1:0]    TSTEP_V = TW'(1);

   if (WST_W < 2) begin : g_bad_wst_w
      $error("wseq_top: WST_W must be at least 2");
   end
   if (HOLD_MAX < 1) begin : g_bad_hold
      $error("wseq_top: HOLD_MAX must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wseq_top: SYNC_STAGES must be at least 2");
   end
   if (WE_RELEASE < 2) begin : g_bad_rel
      $error("wseq_top: WE_RELEASE must be at least 2");
   end

   wseq_state_e      state_q, state_d;
   logic             wait_s;
   logic             low_s;
   logic             load;
   logic             dec;
   logic [WST_W-1:0] wst_eff;
   logic [WST_W-1:0] load_val;
   logic [WST_W-1:0] cnt;
   logic             is_one, is_zero, in_win;
   logic             hit;
   logic             hold_last;
   logic [TW-1:0]    tcnt;
   logic             tail_end;

   wseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (wait_n),
      .q     (wait_s)
   );

   assign low_s    = ~wait_s;
   assign wst_eff  = (wst < MIN_V) ? MIN_V : wst;
   assign load_val = wst_eff - ONE_V;
   assign load     = (state_q == ST_IDLE) && start;
   assign dec      = (state_q == ST_COUNT) && !is_zero && !(is_one && hit);

   wseq_countdown #(.W(WST_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .dec      (dec),
      .cnt      (cnt),
      .is_one   (is_one),
      .is_zero  (is_zero),
      .in_win   (in_win)
   );

   wseq_window u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (load),
      .active (state_q == ST_COUNT),
      .in_win (in_win),
      .low    (low_s),
      .hit    (hit)
   );

   wseq_holdctr #(.HOLD_MAX(HOLD_MAX)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q != ST_HOLD),
      .inc   (state_q == ST_HOLD),
      .last  (hold_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   tcnt <= '0;
      else if (state_q != ST_TAIL)  tcnt <= '0;
      else if (!tail_end)           tcnt <= tcnt + TSTEP_V;
   end

   assign tail_end = (tcnt == TLAST_V);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start) state_d = ST_COUNT;
         ST_COUNT: begin
            if (is_one && hit) state_d = ST_HOLD;
            else if (is_zero)  state_d = ST_DONE;
         end
         ST_HOLD:  if (!low_s || hold_last) state_d = ST_TAIL;
         ST_TAIL:  if (tail_end) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign cs_n = !((state_q == ST_COUNT) || (state_q == ST_HOLD) || (state_q == ST_TAIL));
   assign we_n = !((state_q == ST_COUNT) || (state_q == ST_HOLD) ||
                   ((state_q == ST_TAIL) && !tail_end));
   assign done = (state_q == ST_DONE);
   assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/wseq_checker.sv
module wseq_checker (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic cs_n,
   input logic we_n,
   input logic done,
   input logic busy
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n && we_n && !done));

   assert_strobes_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> $fell(we_n));

   assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_min_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |=> !cs_n ##1 !cs_n);

   assert_cs_lags_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && we_n) |=> cs_n);

   assert_done_with_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(cs_n));

   assert_busy_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

endmodule

bind wseq_top wseq_checker u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .cs_n  (cs_n),
   .we_n  (we_n),
   .done  (done),
   .busy  (busy)
);

// File: tb/sim_wseq_top.sv
`timescale 1ns/1ps
module sim_wseq_top;

   localparam int WST_W    = 6;
   localparam int HOLD_MAX = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [WST_W-1:0] wst = '0;
   logic             wait_n = 1'b1;
   logic             cs_n, we_n, done, busy;

   int n_checks = 0;
   int n_errors = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   wseq_top #(.WST_W(WST_W), .HOLD_MAX(HOLD_MAX)) u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .wst    (wst),
      .wait_n (wait_n),
      .cs_n   (cs_n),
      .we_n   (we_n),
      .done   (done),
      .busy   (busy)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference: phase 0 idle, 1 counting, 2 stretch, 3 closing, 4 done
   int m_ph, mk, mh, mt;
   bit ms1, ms2, mlow, marm;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; mk = 0; mh = 0; mt = 0;
         ms1 = 1'b1; ms2 = 1'b1; marm = 1'b0;
      end else begin
         mlow = !ms2;
         ms2  = ms1;
         ms1  = wait_n;
         case (m_ph)
            0: if (start) begin
                  mk = ((int'(wst) < 3) ? 3 : int'(wst)) - 1;
                  marm = 1'b0;
                  m_ph = 1;
               end
            1: begin
                  if (mlow && mk <= 3) marm = 1'b1;
                  if (mk == 1 && marm) begin m_ph = 2; mh = 0; end
                  else if (mk == 0) m_ph = 4;
                  else mk = mk - 1;
               end
            2: if (!mlow || mh == HOLD_MAX - 1) begin m_ph = 3; mt = 0; end
               else mh = mh + 1;
            3: if (mt == 4) m_ph = 4; else mt = mt + 1;
            default: m_ph = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R3 cs_n vs model", int'(cs_n), (m_ph >= 1 && m_ph <= 3) ? 0 : 1);
         check("R7 we_n vs model", int'(we_n),
               (m_ph == 1 || m_ph == 2 || (m_ph == 3 && mt < 4)) ? 0 : 1);
         check("R3 done vs model", int'(done), (m_ph == 4) ? 1 : 0);
         check("R9 busy vs model", int'(busy), (m_ph != 0) ? 1 : 0);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL R3 watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   // start one cycle; wait_n driven low for loop indices [lo,hi); optional stray start
   task automatic run_seq(input int n, input int lo, input int hi, input int stray,
                          output int cs_len, output int we_len);
      cs_len = 0;
      we_len = 0;
      @(negedge clk);
      start = 1'b1;
      wst = WST_W'(n);
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 300; i++) begin
         if (i > 0) @(negedge clk);
         if (i == 0) begin
            check("R2 cs_n low after start", int'(cs_n), 0);
            check("R2 we_n low after start", int'(we_n), 0);
            check("R2 busy after start", int'(busy), 1);
         end
         if (!cs_n) cs_len++;
         if (!we_n) we_len++;
         if (done) break;
         wait_n = !(i >= lo && i < hi);
         start = (i == stray);
      end
      start = 1'b0;
      wait_n = 1'b1;
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) @(negedge clk);
   endtask

   initial begin
      int cl, wl;
      idle(3);
      check("R1 cs_n in reset", int'(cs_n), 1);
      check("R1 we_n in reset", int'(we_n), 1);
      check("R1 done in reset", int'(done), 0);
      check("R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      idle(3);
      check("R1 cs_n idle", int'(cs_n), 1);

      run_seq(5, -1, -1, -1, cl, wl);
      check("R3 cs low length N=5", cl, 5);
      check("R3 we low length N=5", wl, 5);
      idle(4);

      run_seq(0, -1, -1, -1, cl, wl);
      check("R4 wst=0 clamped", cl, 3);
      idle(4);
      run_seq(2, -1, -1, -1, cl, wl);
      check("R4 wst=2 clamped", cl, 3);
      idle(4);

      run_seq(10, 0, 3, -1, cl, wl);
      check("R5 early wait ignored", cl, 10);
      idle(4);

      run_seq(6, 1, 2, -1, cl, wl);
      check("R6 brief window pulse cs", cl, 11);
      check("R6 brief window pulse we", wl, 10);
      idle(4);

      run_seq(5, 0, 4, -1, cl, wl);
      check("R7 stretch cs release", cl, 12);
      check("R7 stretch we release", wl, 11);
      idle(4);

      run_seq(4, 0, 40, -1, cl, wl);
      check("R8 forced commit cs", cl, 20);
      check("R8 forced commit we", wl, 19);
      idle(4);

      run_seq(5, -1, -1, 2, cl, wl);
      check("R9 stray start length", cl, 5);
      @(negedge clk);
      check("R9 stray start no new cycle", int'(busy), 0);
      idle(3);
      check("R9 still idle", int'(cs_n), 1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule